// File: doc/BRIEF.md
# Bus Transfer-Type Protocol Monitor

This block sits passively beside a pipelined on-chip bus and watches the transfer-type code, address, direction, burst kind, transfer size, lock flag and ready signal on every clock edge. It never drives any bus signal. It looks for misuse of the transfer-type code: continuation beats with no opening beat, pause beats outside a burst, control that drifts in the middle of a burst, incrementing bursts that skip or repeat addresses, and address or control that moves while a wait state holds the previous transfer.

Each kind of violation has its own sticky flag, so a debug or interrupt path can see what went wrong. A single-cycle pulse signals that something new was seen. A synchronous clear input resets the flags without resetting the monitor's view of the burst in progress. Checks on the transfer type, the control and the address are made only in cycles where ready is high, because only those cycles complete an address phase. The wait-state stability check looks at every cycle.

Top module: `xfer_type_monitor`

## Requirements
- R1: While reset is asserted and after it is released, all flags and the pulse read 0, and no burst is open, so a continuation beat is the first thing that can be flagged.
- R2: A continuation beat (code 11) accepted while no burst is open sets flag bit 0. A burst opens on an accepted first beat (code 10) and closes on an accepted idle (code 00).
- R3: A pause beat (code 01) accepted while no burst is open sets flag bit 1.
- R4: An accepted continuation beat inside an open burst whose direction, burst kind or size differs from the opening beat sets flag bit 2.
- R5: For bursts whose opening burst code has bit 0 set (incrementing kinds), an accepted continuation beat must carry the last accepted real-beat address plus 2^size bytes, using the opening beat's size. Any other address sets flag bit 3. Wrapping kinds (bit 0 clear) are not address-checked.
- R6: If the previous cycle had ready low with a non-idle code, then any change in code, address, direction, burst kind, size or lock in the current cycle sets flag bit 4.
- R7: Pause beats inside a burst, and cycles with ready low, raise no flag and do not move the expected next address.
- R8: Flags stay set until the clear input is high at a clock edge. A violation seen in that same cycle is still recorded.
- R9: The pulse output is high for exactly the cycle after each cycle in which at least one violation was detected.
- R10: Idle cycles and legal bursts, including wait states that hold all signals steady, raise no flag and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky flags |
| bus_trans | input | 2 | Transfer-type code: 00 idle, 01 pause, 10 first beat, 11 continuation |
| bus_addr | input | ADDR_W | Address of the current address phase |
| bus_write | input | 1 | Direction, 1 = write |
| bus_burst | input | 3 | Burst kind; bit 0 set means incrementing |
| bus_size | input | 3 | Transfer size as log2 of the byte count |
| bus_lock | input | 1 | Locked-sequence flag |
| bus_ready | input | 1 | High when the current address phase completes |
| err_flags | output | 5 | Sticky flags: bit0 orphan continuation, bit1 orphan pause, bit2 control drift, bit3 address step, bit4 wait-state change |
| err_pulse | output | 1 | One-cycle pulse after any detected violation |

## Verification
The properties assume that every bus input holds a known value from the first clock edge, and that ready is high while reset is asserted. The clear property also assumes that an idle cycle which follows a ready-high cycle cannot violate anything. The stimulus keeps to these assumptions: the bench drives ready high and idle during every reset interval, and it changes inputs only on the falling edge. The bench breaks the protocol on purpose to set each flag, so the properties cover both the legal and the illegal cases without any case being left undriven.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

  localparam int BURST_W = 3;
  localparam int SIZE_W  = 3;
  localparam int NUM_ERR = 5;

  // flag bit positions
  localparam int E_SEQ_ORPHAN  = 0;
  localparam int E_BUSY_ORPHAN = 1;
  localparam int E_CTRL_DRIFT  = 2;
  localparam int E_ADDR_STEP   = 3;
  localparam int E_HOLD_BREAK  = 4;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef struct packed {
    logic               write;
    logic [BURST_W-1:0] burst;
    logic [SIZE_W-1:0]  size;
  } ctrl_t;

endpackage

// File: rtl/xmon_burst_track.sv
module xmon_burst_track
  import xmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trans_e            trans,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic              ready,
  output logic              burst_open,
  output logic              hit_seq_orphan,
  output logic              hit_busy_orphan,
  output logic              hit_drift,
  output logic              hit_step
);

  logic              open_q, open_n;
  ctrl_t             head_q, head_n;
  logic [ADDR_W-1:0] last_q, last_n;
  logic [ADDR_W-1:0] step;
  logic              is_seq, is_busy;

  assign is_seq  = (trans == TR_SEQ);
  assign is_busy = (trans == TR_BUSY);
  assign step    = ADDR_W'(1) << head_q.size;

  always_comb begin
    hit_seq_orphan  = ready && is_seq  && !open_q;
    hit_busy_orphan = ready && is_busy && !open_q;
    hit_drift       = ready && is_seq  && open_q && (ctrl != head_q);
    hit_step        = ready && is_seq  && open_q && head_q.burst[0]
                      && (addr != (last_q + step));
  end

  always_comb begin
    open_n = open_q;
    head_n = head_q;
    last_n = last_q;
    if (ready) begin
      unique case (trans)
        TR_IDLE:   open_n = 1'b0;
        TR_NONSEQ: begin
          open_n = 1'b1;
          head_n = ctrl;
          last_n = addr;
        end
        TR_SEQ:    if (open_q) last_n = addr;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      head_q <= '0;
      last_q <= '0;
    end else if (ready) begin
      open_q <= open_n;
      head_q <= head_n;
      last_q <= last_n;
    end
  end

  assign burst_open = open_q;

endmodule

// File: rtl/xmon_hold_check.sv
module xmon_hold_check
  import xmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trans_e            trans,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic              lock,
  input  logic              ready,
  output logic              hit_hold
);

  trans_e            p_trans;
  logic [ADDR_W-1:0] p_addr;
  ctrl_t             p_ctrl;
  logic              p_lock;
  logic              p_ready;
  logic              pending, moved;

  assign pending = !p_ready && (p_trans != TR_IDLE);

  always_comb begin
    moved = (trans != p_trans) || (addr != p_addr)
            || (ctrl != p_ctrl) || (lock != p_lock);
    hit_hold = pending && moved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_trans <= TR_IDLE;
      p_addr  <= '0;
      p_ctrl  <= '0;
      p_lock  <= 1'b0;
      p_ready <= 1'b1;
    end else begin
      p_trans <= trans;
      p_addr  <= addr;
      p_ctrl  <= ctrl;
      p_lock  <= lock;
      p_ready <= ready;
    end
  end

endmodule

// File: rtl/xmon_err_store.sv
module xmon_err_store #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] hit,
  output logic [N-1:0] flags,
  output logic         pulse
);

  logic [N-1:0] flags_q, flags_n;
  logic         pulse_q, pulse_n;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb flags_n[i] = (clr ? 1'b0 : flags_q[i]) | hit[i];
  end

  assign pulse_n = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      flags_q <= flags_n;
      pulse_q <= pulse_n;
    end
  end

  assign flags = flags_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/xfer_type_monitor.sv
module xfer_type_monitor
  import xmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [1:0]             bus_trans,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_write,
  input  logic [BURST_W-1:0]     bus_burst,
  input  logic [SIZE_W-1:0]      bus_size,
  input  logic                   bus_lock,
  input  logic                   bus_ready,
  output logic [NUM_ERR-1:0]     err_flags,
  output logic                   err_pulse
);

  trans_e             trans;
  ctrl_t              ctrl;
  logic               burst_open;
  logic [NUM_ERR-1:0] hit;

  assign trans      = trans_e'(bus_trans);
  assign ctrl.write = bus_write;
  assign ctrl.burst = bus_burst;
  assign ctrl.size  = bus_size;

  xmon_burst_track #(.ADDR_W(ADDR_W)) u_track (
    .clk             (clk),
    .rst_n           (rst_n),
    .trans           (trans),
    .addr            (bus_addr),
    .ctrl            (ctrl),
    .ready           (bus_ready),
    .burst_open      (burst_open),
    .hit_seq_orphan  (hit[E_SEQ_ORPHAN]),
    .hit_busy_orphan (hit[E_BUSY_ORPHAN]),
    .hit_drift       (hit[E_CTRL_DRIFT]),
    .hit_step        (hit[E_ADDR_STEP])
  );

  xmon_hold_check #(.ADDR_W(ADDR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .trans    (trans),
    .addr     (bus_addr),
    .ctrl     (ctrl),
    .lock     (bus_lock),
    .ready    (bus_ready),
    .hit_hold (hit[E_HOLD_BREAK])
  );

  xmon_err_store #(.N(NUM_ERR)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .hit   (hit),
    .flags (err_flags),
    .pulse (err_pulse)
  );

endmodule

// File: rtl/xfer_type_monitor_chk.sv
module xfer_type_monitor_chk
  import xmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic [1:0]         bus_trans,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_ready,
  input logic               burst_open,
  input logic [NUM_ERR-1:0] err_flags,
  input logic               err_pulse
);

  // R3
  busy_orphan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_trans == 2'b01 && !burst_open) |=> err_flags[E_BUSY_ORPHAN]);

  // R2
  seq_orphan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_trans == 2'b11 && !burst_open) |=> err_flags[E_SEQ_ORPHAN]);

  // R6
  hold_addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!bus_ready && bus_trans != 2'b00) && bus_addr != $past(bus_addr))
      |=> err_flags[E_HOLD_BREAK]);

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && bus_ready && bus_trans == 2'b00 && $past(bus_ready)) |=> (err_flags == '0));

  // R9
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_flags != '0));

  // R10
  nonseq_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == 2'b10 && bus_ready && $past(bus_ready)) |=> !err_pulse);

endmodule

bind xfer_type_monitor xfer_type_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .bus_trans  (bus_trans),
  .bus_addr   (bus_addr),
  .bus_ready  (bus_ready),
  .burst_open (burst_open),
  .err_flags  (err_flags),
  .err_pulse  (err_pulse)
);

// File: tb/xfer_type_monitor_bench.sv
`timescale 1ns/1ps
module xfer_type_monitor_bench;

  typedef struct packed {
    logic [1:0]  tr;
    logic [31:0] ad;
    logic        wr;
    logic [2:0]  bu;
    logic [2:0]  sz;
    logic        lk;
    logic        rdy;
    logic        cl;
    logic [4:0]  ef;
    logic        ep;
  } vec_t;

  localparam int NV = 26;
  // fields: trans, addr, write, burst, size, lock, ready, clear, expected flags, expected pulse
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 0  R10
    '{2'd2, 32'h020, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 1  R10
    '{2'd1, 32'h024, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 2  R7
    '{2'd3, 32'h024, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 3  R7
    '{2'd3, 32'h028, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 4  R10
    '{2'd3, 32'h02C, 1'b0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0}, // 5  R7
    '{2'd3, 32'h02C, 1'b0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0}, // 6  R7
    '{2'd3, 32'h02C, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 7  R7
    '{2'd0, 32'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 5'b00000, 1'b0}, // 8  R10
    '{2'd3, 32'h030, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00001, 1'b1}, // 9  R2
    '{2'd0, 32'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 5'b00001, 1'b0}, // 10 R9
    '{2'd0, 32'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 5'b00000, 1'b0}, // 11 R8
    '{2'd1, 32'h040, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00010, 1'b1}, // 12 R3
    '{2'd2, 32'h100, 1'b1, 3'd3, 3'd2, 1'b0, 1'b1, 1'b0, 5'b00010, 1'b0}, // 13 R9
    '{2'd3, 32'h104, 1'b1, 3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 5'b00110, 1'b1}, // 14 R4
    '{2'd3, 32'h10C, 1'b1, 3'd3, 3'd2, 1'b0, 1'b1, 1'b0, 5'b01110, 1'b1}, // 15 R5
    '{2'd2, 32'h200, 1'b0, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0, 5'b01110, 1'b0}, // 16 R9
    '{2'd3, 32'h20C, 1'b0, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0, 5'b01110, 1'b0}, // 17 R5
    '{2'd2, 32'h300, 1'b0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 5'b01110, 1'b0}, // 18 R6
    '{2'd2, 32'h304, 1'b0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 5'b11110, 1'b1}, // 19 R6
    '{2'd2, 32'h304, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b11110, 1'b0}, // 20 R6
    '{2'd0, 32'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 5'b00000, 1'b0}, // 21 R8
    '{2'd3, 32'h308, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b1, 5'b00001, 1'b1}, // 22 R8
    '{2'd0, 32'h000, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 5'b00001, 1'b0}, // 23 R9
    '{2'd2, 32'h400, 1'b0, 3'd1, 3'd2, 1'b1, 1'b0, 1'b0, 5'b00001, 1'b0}, // 24 R6
    '{2'd2, 32'h400, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 5'b10001, 1'b1}  // 25 R6
  };

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic [1:0]  bus_trans;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [2:0]  bus_burst;
  logic [2:0]  bus_size;
  logic        bus_lock;
  logic        bus_ready;
  logic [4:0]  err_flags;
  logic        err_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  xfer_type_monitor #(.ADDR_W(32)) u_xfer_type_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .bus_trans (bus_trans),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_burst (bus_burst),
    .bus_size  (bus_size),
    .bus_lock  (bus_lock),
    .bus_ready (bus_ready),
    .err_flags (err_flags),
    .err_pulse (err_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_of(int i);
    case (i)
      2, 3, 5, 6, 7:      return "R7";
      9:                  return "R2";
      11, 21, 22:         return "R8";
      12:                 return "R3";
      14:                 return "R4";
      15, 17:             return "R5";
      18, 19, 20, 24, 25: return "R6";
      10, 13, 16, 23:     return "R9";
      default:            return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [4:0] ef, logic ep);
    total++;
    if (err_flags !== ef || err_pulse !== ep) begin
      bad++;
      $display("FAIL %s: flags=%b pulse=%b expected flags=%b pulse=%b",
               req, err_flags, err_pulse, ef, ep);
    end
  endtask

  task automatic drive(logic [1:0] tr, logic [31:0] ad, logic wr, logic [2:0] bu,
                       logic [2:0] sz, logic lk, logic rdy, logic cl);
    bus_trans = tr; bus_addr = ad; bus_write = wr; bus_burst = bu;
    bus_size = sz; bus_lock = lk; bus_ready = rdy; clr = cl;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(2'd0, 32'h0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 5'b00000, 1'b0);   // state during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 5'b00000, 1'b0);   // state just after reset

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].tr, VECS[i].ad, VECS[i].wr, VECS[i].bu,
            VECS[i].sz, VECS[i].lk, VECS[i].rdy, VECS[i].cl);
      @(posedge clk);
      @(negedge clk);
      check(req_of(i), VECS[i].ef, VECS[i].ep);
    end

    // R9: pulse lasts a single cycle after the row 25 violation
    drive(2'd0, 32'h0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R9", 5'b10001, 1'b0);

    // R1: open a burst, reset in the middle, then a continuation is orphaned
    drive(2'd2, 32'h500, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(2'd0, 32'h0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 5'b00000, 1'b0);
    rst_n = 1'b1;
    drive(2'd3, 32'h504, 1'b0, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1", 5'b00001, 1'b1);

    // R7: pause inside a burst keeps the expected address; byte-size step
    drive(2'd1, 32'h0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R3", 5'b00010, 1'b1);  // pause with no burst open, clear same cycle
    drive(2'd2, 32'h600, 1'b0, 3'd7, 3'd0, 1'b0, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R8", 5'b00000, 1'b0);
    drive(2'd1, 32'h601, 1'b0, 3'd7, 3'd0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(2'd3, 32'h601, 1'b0, 3'd7, 3'd0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R7", 5'b00000, 1'b0);
    drive(2'd3, 32'h603, 1'b0, 3'd7, 3'd0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R5", 5'b01000, 1'b1);

    finish_run();
  end

endmodule